// File: doc/BRIEF.md
# Processor-to-Peripheral Bus Bridge

This block connects the data port of a small processor to two kinds of target. Each load or store is decoded by address. A bank of word registers inside the bridge answers after a fixed short delay. A wide external region is passed on to an I/O bus as one read or write strobe, with address, byte enables and write data. The bridge then waits for the addressed target to return a ready pulse. The read data, or zero for a store, goes back to the processor together with a one-cycle acknowledge.

The processor raises `cpu_req` for one cycle and then waits for `cpu_ack`. The bridge handles one access at a time and ignores any request that arrives while an access is still open. An access to an address that nothing decodes still completes, so the processor never hangs. The same holds for an external access whose target stays silent past a set number of cycles. In both cases the read data is zero and a sticky error flag is raised. The flag clears only on reset.

Top module: `pbus_bridge`

## Requirements
- R1: While reset is high and in the cycle after it, `cpu_ack`, `ext_rd`, `ext_wr`, `err_flag` and `cpu_rdata` are all zero.
- R2: The local register bank holds NREGS 32-bit words. Word i sits at byte address 0x8000_0000 + 4*i, and address bits [log2(NREGS)+1:2] select the word.
- R3: A load to the local bank issued in cycle c is acknowledged in cycle c+2. It returns the stored word.
- R4: A store to the local bank writes byte lane k (bits 8k+7..8k) only when `cpu_be[k]` is 1, and leaves the other lanes unchanged. A load issued in the acknowledge cycle of the store sees the new value.
- R5: An access to 0xC000_0000..0xFFFF_FFFF issued in cycle c raises exactly one strobe in cycle c+1: `ext_rd` for a load or `ext_wr` for a store, never both. In that cycle `ext_addr`, `ext_be` and `ext_wdata` carry the request's values.
- R6: The target may raise `ext_ready` in the strobe cycle or W cycles later. The processor is then acknowledged in cycle c+3+W. A load returns the `ext_rdata` that was present with ready.
- R7: A request raised while an access is still open is ignored. It makes no strobe, no acknowledge and no register write.
- R8: Two external strobes are always at least three cycles apart, even when the next request is issued in the acknowledge cycle.
- R9: Addresses below 0x8000_0000, and addresses from 0x8000_0000 + 4*NREGS up to 0xBFFF_FFFF, are unmapped. Such an access is acknowledged in cycle c+2 with zero data, sets `err_flag`, and writes nothing.
- R10: If ready does not arrive within TIMEOUT_CYC cycles (W >= TIMEOUT_CYC), the access is acknowledged in cycle c+TIMEOUT_CYC+2 with zero data and sets `err_flag`. A ready that arrives after this is ignored.
- R11: `err_flag` stays set until reset, whatever accesses follow.
- R12: `cpu_ack` is high for a single cycle per accepted access. Store acknowledges carry zero read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | One-cycle access request |
| cpu_we | input | 1 | 1 for a store, 0 for a load |
| cpu_addr | input | 32 | Byte address |
| cpu_be | input | 4 | Byte enables for stores |
| cpu_wdata | input | 32 | Store data |
| cpu_ack | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Load data, valid with acknowledge |
| err_flag | output | 1 | Sticky unmapped or timeout error |
| ext_addr | output | 32 | External bus address |
| ext_wdata | output | 32 | External bus write data |
| ext_be | output | 4 | External bus byte enables |
| ext_rd | output | 1 | One-cycle external read strobe |
| ext_wr | output | 1 | One-cycle external write strobe |
| ext_rdata | input | 32 | External read data, qualified by ready |
| ext_ready | input | 1 | Target completion pulse |

## Verification
The assertions check on every cycle that the acknowledge is a single pulse and that the two strobes never coincide. They also check that strobes keep their three-cycle spacing, that a request during an open access never produces a strobe, and that a local or unmapped access is acknowledged exactly two cycles after it is issued. A counter in the checker bounds how long the bridge can stay busy, which makes the timeout visible. The error flag is checked for never falling outside reset. Only the bench scenarios can show stored values and byte-lane merging, the wait-state-dependent acknowledge cycle, the forwarded address and data, the decode boundaries, and that an ignored or unmapped store left the register contents alone.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
  localparam int DW = 32;
  localparam int BW = DW / 8;
  localparam logic [1:0] LOCAL_TOP = 2'b10;
  localparam logic [1:0] EXT_TOP   = 2'b11;

  typedef enum logic [1:0] {
    RG_NONE  = 2'd0,
    RG_LOCAL = 2'd1,
    RG_EXT   = 2'd2
  } region_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOCAL = 2'd1,
    ST_EXT   = 2'd2
  } top_state_e;
endpackage

// File: rtl/pbus_decode.sv
module pbus_decode
  import pbus_pkg::*;
#(
  parameter int NREGS = 16,
  localparam int IDX_W = (NREGS > 1) ? $clog2(NREGS) : 1
) (
  input  logic [DW-1:0]    addr,
  output region_e          region,
  output logic [IDX_W-1:0] idx
);
  localparam logic [29:0] LOCAL_SPAN = 30'(NREGS * 4);

  always_comb begin
    if (addr[31:30] == EXT_TOP)
      region = RG_EXT;
    else if ((addr[31:30] == LOCAL_TOP) && (addr[29:0] < LOCAL_SPAN))
      region = RG_LOCAL;
    else
      region = RG_NONE;
  end

  assign idx = addr[IDX_W+1:2];
endmodule

// File: rtl/pbus_regfile.sv
module pbus_regfile
  import pbus_pkg::*;
#(
  parameter int NREGS = 16,
  localparam int IDX_W = (NREGS > 1) ? $clog2(NREGS) : 1
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [BW-1:0]    be,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata
);
  for (genvar g = 0; g < BW; g++) begin : g_lane
    logic [7:0] lane_mem [NREGS];
    logic [7:0] lane_q;

    always_ff @(posedge clk) begin
      if (wr_en && be[g])
        lane_mem[idx] <= wdata[8*g +: 8];
      if (rd_en)
        lane_q <= lane_mem[idx];
    end

    assign rdata[8*g +: 8] = lane_q;
  end
endmodule

// File: rtl/pbus_extport.sv
module pbus_extport
  import pbus_pkg::*;
#(
  parameter int TIMEOUT_CYC = 8,
  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          we,
  input  logic [DW-1:0] addr,
  input  logic [BW-1:0] be,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] ext_addr,
  output logic [DW-1:0] ext_wdata,
  output logic [BW-1:0] ext_be,
  output logic          ext_rd,
  output logic          ext_wr,
  input  logic [DW-1:0] ext_rdata,
  input  logic          ext_ready,
  output logic          done,
  output logic          done_err,
  output logic [DW-1:0] done_data
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYC - 1);

  logic             waiting;
  logic             we_q;
  logic [CNT_W-1:0] wait_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      waiting   <= 1'b0;
      we_q      <= 1'b0;
      wait_cnt  <= '0;
      ext_addr  <= '0;
      ext_wdata <= '0;
      ext_be    <= '0;
      ext_rd    <= 1'b0;
      ext_wr    <= 1'b0;
      done      <= 1'b0;
      done_err  <= 1'b0;
      done_data <= '0;
    end else begin
      ext_rd <= 1'b0;
      ext_wr <= 1'b0;
      done   <= 1'b0;
      if (!waiting) begin
        if (start) begin
          ext_addr  <= addr;
          ext_wdata <= wdata;
          ext_be    <= be;
          ext_rd    <= !we;
          ext_wr    <= we;
          we_q      <= we;
          wait_cnt  <= '0;
          waiting   <= 1'b1;
        end
      end else if (ext_ready) begin
        done      <= 1'b1;
        done_err  <= 1'b0;
        done_data <= we_q ? '0 : ext_rdata;
        waiting   <= 1'b0;
      end else if (wait_cnt == LAST) begin
        done      <= 1'b1;
        done_err  <= 1'b1;
        done_data <= '0;
        waiting   <= 1'b0;
      end else begin
        wait_cnt <= wait_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pbus_bridge.sv
module pbus_bridge
  import pbus_pkg::*;
#(
  parameter int NREGS       = 16,
  parameter int TIMEOUT_CYC = 8,
  localparam int IDX_W = (NREGS > 1) ? $clog2(NREGS) : 1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cpu_req,
  input  logic        cpu_we,
  input  logic [31:0] cpu_addr,
  input  logic [3:0]  cpu_be,
  input  logic [31:0] cpu_wdata,
  output logic        cpu_ack,
  output logic [31:0] cpu_rdata,
  output logic        err_flag,
  output logic [31:0] ext_addr,
  output logic [31:0] ext_wdata,
  output logic [3:0]  ext_be,
  output logic        ext_rd,
  output logic        ext_wr,
  input  logic [31:0] ext_rdata,
  input  logic        ext_ready
);
  top_state_e       state;
  region_e          region;
  logic [IDX_W-1:0] idx;
  logic             accept;
  logic             ext_start;
  logic             near_accept;
  logic             top_idle;
  logic             miss_q;
  logic             we_q;
  logic [DW-1:0]    rf_rdata;
  logic             x_done;
  logic             x_err;
  logic [DW-1:0]    x_data;

  pbus_decode #(.NREGS(NREGS)) u_dec (
    .addr   (cpu_addr),
    .region (region),
    .idx    (idx)
  );

  assign top_idle    = (state == ST_IDLE);
  assign accept      = cpu_req && top_idle;
  assign ext_start   = accept && (region == RG_EXT);
  assign near_accept = accept && (region != RG_EXT);

  pbus_regfile #(.NREGS(NREGS)) u_rf (
    .clk   (clk),
    .wr_en (accept && (region == RG_LOCAL) && cpu_we),
    .rd_en (accept && (region == RG_LOCAL) && !cpu_we),
    .idx   (idx),
    .be    (cpu_be),
    .wdata (cpu_wdata),
    .rdata (rf_rdata)
  );

  pbus_extport #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_ext (
    .clk       (clk),
    .rst       (rst),
    .start     (ext_start),
    .we        (cpu_we),
    .addr      (cpu_addr),
    .be        (cpu_be),
    .wdata     (cpu_wdata),
    .ext_addr  (ext_addr),
    .ext_wdata (ext_wdata),
    .ext_be    (ext_be),
    .ext_rd    (ext_rd),
    .ext_wr    (ext_wr),
    .ext_rdata (ext_rdata),
    .ext_ready (ext_ready),
    .done      (x_done),
    .done_err  (x_err),
    .done_data (x_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cpu_ack   <= 1'b0;
      cpu_rdata <= '0;
      err_flag  <= 1'b0;
      miss_q    <= 1'b0;
      we_q      <= 1'b0;
    end else begin
      cpu_ack <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            miss_q <= (region == RG_NONE);
            we_q   <= cpu_we;
            state  <= (region == RG_EXT) ? ST_EXT : ST_LOCAL;
          end
        end
        ST_LOCAL: begin
          cpu_ack   <= 1'b1;
          cpu_rdata <= (miss_q || we_q) ? '0 : rf_rdata;
          if (miss_q) err_flag <= 1'b1;
          state <= ST_IDLE;
        end
        ST_EXT: begin
          if (x_done) begin
            cpu_ack   <= 1'b1;
            cpu_rdata <= x_data;
            if (x_err) err_flag <= 1'b1;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pbus_bridge_chk.sv
module pbus_bridge_chk #(
  parameter int TIMEOUT_CYC = 8,
  localparam int CW = $clog2(TIMEOUT_CYC + 3)
) (
  input logic clk,
  input logic rst,
  input logic cpu_req,
  input logic cpu_ack,
  input logic err_flag,
  input logic ext_rd,
  input logic ext_wr,
  input logic top_idle,
  input logic near_accept
);
  localparam logic [CW-1:0] BUSY_MAX = CW'(TIMEOUT_CYC + 1);

  logic [CW-1:0] busy_cnt;

  always_ff @(posedge clk) begin
    if (rst || top_idle) busy_cnt <= '0;
    else if (busy_cnt != BUSY_MAX + 1'b1) busy_cnt <= busy_cnt + 1'b1;
  end

  p_ack_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    cpu_ack |=> !cpu_ack);

  p_strobe_excl_r5: assert property (@(posedge clk) disable iff (rst)
    !(ext_rd && ext_wr));

  p_strobe_gap_r8: assert property (@(posedge clk) disable iff (rst)
    (ext_rd || ext_wr) |=> (!(ext_rd || ext_wr) ##1 !(ext_rd || ext_wr)));

  p_err_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    err_flag |=> err_flag);

  p_local_latency_r3: assert property (@(posedge clk) disable iff (rst)
    near_accept |=> (!cpu_ack ##1 cpu_ack));

  p_busy_ignore_r7: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && !top_idle) |=> !(ext_rd || ext_wr));

  p_timeout_bound_r10: assert property (@(posedge clk) disable iff (rst)
    busy_cnt <= BUSY_MAX);
endmodule

bind pbus_bridge pbus_bridge_chk #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cpu_req     (cpu_req),
  .cpu_ack     (cpu_ack),
  .err_flag    (err_flag),
  .ext_rd      (ext_rd),
  .ext_wr      (ext_wr),
  .top_idle    (top_idle),
  .near_accept (near_accept)
);

// File: tb/pbus_bridge_test.sv
module pbus_bridge_test;
  localparam int NREGS = 16;
  localparam int TMO   = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_req = 1'b0;
  logic        cpu_we = 1'b0;
  logic [31:0] cpu_addr = '0;
  logic [3:0]  cpu_be = '0;
  logic [31:0] cpu_wdata = '0;
  logic        cpu_ack;
  logic [31:0] cpu_rdata;
  logic        err_flag;
  logic [31:0] ext_addr;
  logic [31:0] ext_wdata;
  logic [3:0]  ext_be;
  logic        ext_rd;
  logic        ext_wr;
  logic [31:0] ext_rdata = '0;
  logic        ext_ready = 1'b0;

  int checks = 0;
  int fails  = 0;
  bit done_flag = 1'b0;

  logic [31:0] model [NREGS];

  logic [31:0] r_data;
  int          r_ackk;
  int          r_acks;
  int          r_strobes;
  int          r_stk;
  logic        r_stwr;
  logic [31:0] r_saddr;
  logic [31:0] r_swdata;
  logic [3:0]  r_sbe;

  always #2.5 clk = ~clk;

  pbus_bridge #(.NREGS(NREGS), .TIMEOUT_CYC(TMO)) uut (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_be(cpu_be), .cpu_wdata(cpu_wdata),
    .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata), .err_flag(err_flag),
    .ext_addr(ext_addr), .ext_wdata(ext_wdata), .ext_be(ext_be),
    .ext_rd(ext_rd), .ext_wr(ext_wr), .ext_rdata(ext_rdata),
    .ext_ready(ext_ready)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  function automatic logic [31:0] bemask(input logic [3:0] be);
    return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  endfunction

  // Issue one request in cycle 0; the target raises ready in cycle 1+w
  // (w<0: never). Optionally poke a second request in cycle pk.
  task automatic access(input logic we, input logic [31:0] addr,
                        input logic [3:0] be, input logic [31:0] wd,
                        input int w, input logic [31:0] tdata,
                        input int pk, input logic [31:0] paddr);
    r_ackk = -1; r_acks = 0; r_strobes = 0; r_stk = -1; r_data = '0;
    r_stwr = 1'b0; r_saddr = '0; r_swdata = '0; r_sbe = '0;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_be = be; cpu_wdata = wd;
    for (int k = 1; k <= 16; k++) begin
      @(negedge clk);
      cpu_req = (k == pk);
      if (k == pk) begin
        cpu_we = 1'b1; cpu_addr = paddr; cpu_be = 4'hF; cpu_wdata = 32'hDEAD_BEEF;
      end
      ext_ready = (w >= 0) && (k == 1 + w);
      ext_rdata = ((w >= 0) && (k == 1 + w)) ? tdata : 32'h1357_9BDF;
      if (ext_rd || ext_wr) begin
        r_strobes++;
        if (r_stk < 0) begin
          r_stk = k; r_stwr = ext_wr; r_saddr = ext_addr;
          r_swdata = ext_wdata; r_sbe = ext_be;
        end
      end
      if (cpu_ack) begin
        r_acks++;
        if (r_ackk < 0) begin
          r_ackk = k; r_data = cpu_rdata;
        end
      end
    end
    ext_ready = 1'b0;
  endtask

  initial begin
    #(5.0 * 190000);
    if (!done_flag) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    @(negedge clk);
    @(negedge clk);
    chk(cpu_ack == 1'b0, "R1 ack in reset", 32'(cpu_ack), 0);
    chk(!ext_rd && !ext_wr, "R1 strobes in reset", 32'({ext_rd, ext_wr}), 0);
    chk(err_flag == 1'b0, "R1 err in reset", 32'(err_flag), 0);
    chk(cpu_rdata == '0, "R1 rdata in reset", cpu_rdata, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!cpu_ack && !err_flag, "R1 after reset", 32'({cpu_ack, err_flag}), 0);

    // R2/R12: fill the bank with full-lane stores
    for (int i = 0; i < NREGS; i++) begin
      logic [31:0] v;
      v = 32'hA500_0000 ^ (32'(i) * 32'h0101_0101);
      access(1'b1, 32'h8000_0000 + 32'(4 * i), 4'hF, v, -1, 0, 0, 0);
      model[i] = v;
      chk(r_ackk == 2, "R12 store ack cycle", 32'(r_ackk), 2);
      chk(r_acks == 1 && r_data == 0, "R12 store ack pulse/data", r_data, 0);
    end
    for (int i = 0; i < NREGS; i++) begin
      access(1'b0, 32'h8000_0000 + 32'(4 * i), 4'hF, 0, -1, 0, 0, 0);
      chk(r_ackk == 2, "R3 load ack cycle", 32'(r_ackk), 2);
      chk(r_data == model[i], "R2 load word at index", r_data, model[i]);
      chk(r_strobes == 0, "R2 local makes no strobe", 32'(r_strobes), 0);
    end

    // R4: every byte-enable pattern on every word
    for (int i = 0; i < NREGS; i++) begin
      for (int b = 0; b < 16; b++) begin
        logic [31:0] v;
        v = {8'(i), 8'(b), ~8'(i), 8'h5A} ^ 32'h0F0F_3C3C;
        access(1'b1, 32'h8000_0000 + 32'(4 * i), 4'(b), v, -1, 0, 0, 0);
        model[i] = (model[i] & ~bemask(4'(b))) | (v & bemask(4'(b)));
        access(1'b0, 32'h8000_0000 + 32'(4 * i), 4'h0, 0, -1, 0, 0, 0);
        chk(r_data == model[i], "R4 byte lane merge", r_data, model[i]);
      end
    end

    // R5/R6/R10: external sweep over wait states, loads and stores
    for (int w = 0; w <= TMO + 1; w++) begin
      for (int we = 0; we < 2; we++) begin
        logic [31:0] a;
        logic [31:0] td;
        int exp_k;
        do_reset();
        a  = 32'hC000_0000 + 32'(w * 64 + we * 4) + (we != 0 ? 32'h3000_0000 : 0);
        td = 32'h6000_0000 + 32'(w * 17 + we);
        access(1'(we), a, 4'(w + 3), ~td, w, td, 0, 0);
        exp_k = (w < TMO) ? 3 + w : TMO + 2;
        chk(r_strobes == 1 && r_stk == 1, "R5 one strobe in cycle 1", 32'(r_stk), 1);
        chk(r_stwr == 1'(we), "R5 strobe kind", 32'(r_stwr), 32'(we));
        chk(r_saddr == a && r_sbe == 4'(w + 3) && r_swdata == ~td,
            "R5 forwarded address/be/data", r_saddr, a);
        chk(r_ackk == exp_k && r_acks == 1, (w < TMO) ? "R6 ack cycle" : "R10 ack cycle",
            32'(r_ackk), 32'(exp_k));
        chk(r_data == ((w < TMO && we == 0) ? td : 0),
            (w < TMO) ? "R6 returned data" : "R10 zero data", r_data,
            (w < TMO && we == 0) ? td : 0);
        chk(err_flag == (w >= TMO), "R10 error flag", 32'(err_flag), 32'(w >= TMO));
      end
    end

    // R7: request while external access is open
    do_reset();
    access(1'b0, 32'hC000_0100, 4'hF, 0, 4, 32'h1111_2222, 2, 32'h8000_0000);
    chk(r_strobes == 1 && r_acks == 1, "R7 busy request ignored (ext)",
        32'(r_strobes * 16 + r_acks), 17);
    chk(r_data == 32'h1111_2222, "R7 first access unaffected", r_data, 32'h1111_2222);
    access(1'b0, 32'h8000_0004, 4'hF, 0, -1, 0, 1, 32'hC000_0000);
    chk(r_strobes == 0 && r_acks == 1, "R7 busy request ignored (local)",
        32'(r_strobes * 16 + r_acks), 1);
    access(1'b0, 32'h8000_0000, 4'hF, 0, -1, 0, 0, 0);
    chk(r_data == model[0], "R7 ignored store wrote nothing", r_data, model[0]);

    // R8: next external request issued in the acknowledge cycle
    begin
      int s1;
      int s2;
      int nst;
      s1 = -1; s2 = -1; nst = 0;
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 32'hD000_0000; cpu_be = 4'hF;
      for (int k = 1; k <= 10; k++) begin
        @(negedge clk);
        cpu_req = 1'b0;
        ext_ready = (k == 1) || (k == 4);
        if (ext_rd || ext_wr) begin
          nst++;
          if (s1 < 0) s1 = k; else s2 = k;
        end
        if (cpu_ack && k == 3) begin
          cpu_req = 1'b1; cpu_addr = 32'hD000_0010;
        end
      end
      ext_ready = 1'b0;
      chk(nst == 2 && s1 == 1, "R8 first strobe", 32'(s1), 1);
      chk(s2 == 4, "R8 strobe spacing three cycles", 32'(s2), 4);
    end

    // R9/R11: unmapped addresses
    do_reset();
    access(1'b0, 32'h8000_0008, 4'hF, 0, -1, 0, 0, 0);
    chk(err_flag == 0, "R9 mapped access sets no error", 32'(err_flag), 0);
    begin
      logic [31:0] bad [4];
      bad[0] = 32'h0000_0000;
      bad[1] = 32'h7FFF_FFFC;
      bad[2] = 32'h8000_0000 + 32'(4 * NREGS);
      bad[3] = 32'hBFFF_FFFC;
      for (int j = 0; j < 4; j++) begin
        access(1'b0, bad[j], 4'hF, 0, -1, 0, 0, 0);
        chk(r_ackk == 2 && r_data == 0 && r_strobes == 0, "R9 unmapped load",
            r_data, 0);
        chk(err_flag == 1, "R9 unmapped sets error", 32'(err_flag), 1);
      end
    end
    access(1'b1, 32'h8000_0000 + 32'(4 * NREGS), 4'hF, 32'hFFFF_FFFF, -1, 0, 0, 0);
    chk(r_ackk == 2, "R9 unmapped store ack", 32'(r_ackk), 2);
    access(1'b0, 32'h8000_0000, 4'hF, 0, -1, 0, 0, 0);
    chk(r_data == model[0], "R9 unmapped store wrote nothing", r_data, model[0]);
    access(1'b0, 32'hC000_0000, 4'hF, 0, 0, 32'h2, 0, 0);
    chk(err_flag == 1, "R11 error stays set", 32'(err_flag), 1);
    do_reset();
    chk(err_flag == 0, "R11 reset clears error", 32'(err_flag), 0);

    done_flag = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule